// File: doc/BRIEF.md
# Ethernet Test Frame Generator

This block sits in front of a PHY transmit path. It is a built-in source of test traffic. When the generator is enabled, the byte stream from the MAC is shut out and the block sends Ethernet frames that it assembles itself. It sends one byte per clock, with a valid strobe, on a GMII-style byte interface. A small register port sets up each frame:

- the destination and source addresses,
- the length/type field,
- the payload length and the payload byte,
- the idle gap between frames,
- whether the frame check sequence is correct or deliberately broken.

A run bit starts traffic. In burst mode the run bit clears itself after a fixed number of frames. In continuous mode frames repeat until software clears the run bit. Receive data from the PHY is passed through to the MAC with one register stage. A separate control bit forces that receive path quiet.

Top module: `eth_test_gen`

## Requirements
- R1: Each generated frame is sent in this order: 7 bytes of 0x55, one byte of 0xD5, the 6 destination bytes, the 6 source bytes, the 2-byte type field, the payload, and 4 FCS bytes. Address bytes go most significant first: register 1 bits 15:8 is the first destination byte and register 4 bits 15:8 is the first source byte. The type field comes from register 7, high byte first.
- R2: While the generator-enable bit (control bit 0) is 1, the MAC transmit inputs never reach the PHY transmit outputs. While it is 0, mac_txd and mac_tx_en appear on phy_txd and phy_tx_en one clock later.
- R3: Frames start only while both generator-enable and run (control bit 1) are 1.
- R4: With continuous mode (control bit 2) at 0, run clears itself after exactly BURST_LIMIT frames (default 30,000,000). The frame counter restarts each time run goes from 0 to 1.
- R5: With continuous mode at 1, frames repeat past BURST_LIMIT. Clearing run in the middle of a frame lets that frame finish complete before transmission stops.
- R6: Between consecutive frames, phy_tx_en is low for exactly the number of clocks held in register 9. A value of 0 makes frames back to back.
- R7: The payload holds exactly as many bytes as register 8 says, and every payload byte equals register 10 bits 7:0. A length of 0 leaves the payload out.
- R8: With the bad-FCS bit (control bit 3) at 0, the FCS is the reflected CRC-32 (polynomial 0x04C11DB7, start value all ones, final inversion) over the destination through the payload. It is sent least significant byte first.
- R9: With the bad-FCS bit at 1, each FCS byte is the bitwise inverse of the correct byte.
- R10: With the receive-off bit (control bit 4) at 1, mac_rx_dv and mac_rxd are held at 0. With it at 0, phy_rxd and phy_rx_dv reach the MAC one clock later, whatever the state of generator-enable.
- R11: reg_rdata returns the register addressed in the previous clock. The run bit read back shows the self-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (0 control, 1-3 destination, 4-6 source, 7 type, 8 payload length, 9 gap, 10 pattern) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| mac_txd | input | 8 | Transmit byte from the MAC |
| mac_tx_en | input | 1 | Transmit valid from the MAC |
| phy_txd | output | 8 | Transmit byte toward the PHY |
| phy_tx_en | output | 1 | Transmit valid toward the PHY |
| phy_rxd | input | 8 | Receive byte from the PHY |
| phy_rx_dv | input | 1 | Receive valid from the PHY |
| mac_rxd | output | 8 | Receive byte toward the MAC |
| mac_rx_dv | output | 1 | Receive valid toward the MAC |

## Verification
Frame generation is driven with four settings. They cover the empty payload with a zero gap, a one-byte payload with a broken FCS, and mid-size and minimum-Ethernet payloads with different fill bytes and gaps. Together these separate errors in the field order, in the payload count, in the gap count and in CRC handling of both polarities. The MAC keeps offering a garbage byte during all of these runs, so any leak through the multiplexer breaks the byte compare. Each burst is checked for exactly the expected frame count, which exposes a counter that does not restart or an off-by-one stop. A continuous run beyond the burst limit, with run cleared mid-frame, shows whether the current frame is cut short.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;
  localparam int PRE_N  = 7;
  localparam int ADR_N  = 6;
  localparam int FCS_N  = 4;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_DA0  = 4'd1;
  localparam logic [ADDR_W-1:0] A_DA1  = 4'd2;
  localparam logic [ADDR_W-1:0] A_DA2  = 4'd3;
  localparam logic [ADDR_W-1:0] A_SA0  = 4'd4;
  localparam logic [ADDR_W-1:0] A_SA1  = 4'd5;
  localparam logic [ADDR_W-1:0] A_SA2  = 4'd6;
  localparam logic [ADDR_W-1:0] A_TYPE = 4'd7;
  localparam logic [ADDR_W-1:0] A_LEN  = 4'd8;
  localparam logic [ADDR_W-1:0] A_GAP  = 4'd9;
  localparam logic [ADDR_W-1:0] A_PAT  = 4'd10;

  typedef struct packed {
    logic             gen_en;
    logic             run;
    logic             cont;
    logic             bad_fcs;
    logic             rx_off;
    logic [47:0]      da;
    logic [47:0]      sa;
    logic [REG_W-1:0] etype;
    logic [REG_W-1:0] pay_len;
    logic [REG_W-1:0] gap;
    logic [7:0]       pattern;
  } tpg_cfg_t;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_SFD, S_DA, S_SA, S_TYPE, S_PAY, S_FCS, S_GAP
  } tpg_state_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] pick_byte(input logic [47:0] w, input logic [2:0] i);
    case (i)
      3'd0:    return w[47:40];
      3'd1:    return w[39:32];
      3'd2:    return w[31:24];
      3'd3:    return w[23:16];
      3'd4:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction
endpackage

// File: rtl/tpg_regs.sv
module tpg_regs
  import tpg_pkg::*;
#(
  parameter int BURST_LIMIT = 30_000_000,
  parameter int CNT_W       = $clog2(BURST_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              frame_done,
  output tpg_cfg_t          cfg,
  output logic              go
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BURST_LIMIT - 1);
  localparam logic [CNT_W-1:0] LIM_CNT  = CNT_W'(BURST_LIMIT);

  logic [CNT_W-1:0] frame_cnt;
  logic             run_q;
  logic             stop_now;
  logic             ctrl_wr;

  assign ctrl_wr  = reg_we && (reg_addr == A_CTRL);
  assign stop_now = frame_done && !cfg.cont && (frame_cnt >= LAST_CNT);
  assign go       = cfg.gen_en && cfg.run && !stop_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          A_CTRL: {cfg.rx_off, cfg.bad_fcs, cfg.cont, cfg.run, cfg.gen_en} <= reg_wdata[4:0];
          A_DA0:  cfg.da[47:32] <= reg_wdata;
          A_DA1:  cfg.da[31:16] <= reg_wdata;
          A_DA2:  cfg.da[15:0]  <= reg_wdata;
          A_SA0:  cfg.sa[47:32] <= reg_wdata;
          A_SA1:  cfg.sa[31:16] <= reg_wdata;
          A_SA2:  cfg.sa[15:0]  <= reg_wdata;
          A_TYPE: cfg.etype     <= reg_wdata;
          A_LEN:  cfg.pay_len   <= reg_wdata;
          A_GAP:  cfg.gap       <= reg_wdata;
          A_PAT:  cfg.pattern   <= reg_wdata[7:0];
          default: ;
        endcase
      end
      if (stop_now && !ctrl_wr) cfg.run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_cnt <= '0;
      run_q     <= 1'b0;
    end else begin
      run_q <= cfg.run;
      if (cfg.run && !run_q)                     frame_cnt <= '0;
      else if (frame_done && frame_cnt < LIM_CNT) frame_cnt <= frame_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= {11'd0, cfg.rx_off, cfg.bad_fcs, cfg.cont, cfg.run, cfg.gen_en};
        A_DA0:   reg_rdata <= cfg.da[47:32];
        A_DA1:   reg_rdata <= cfg.da[31:16];
        A_DA2:   reg_rdata <= cfg.da[15:0];
        A_SA0:   reg_rdata <= cfg.sa[47:32];
        A_SA1:   reg_rdata <= cfg.sa[31:16];
        A_SA2:   reg_rdata <= cfg.sa[15:0];
        A_TYPE:  reg_rdata <= cfg.etype;
        A_LEN:   reg_rdata <= cfg.pay_len;
        A_GAP:   reg_rdata <= cfg.gap;
        A_PAT:   reg_rdata <= {8'd0, cfg.pattern};
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R4: the counter never passes the burst limit
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst) frame_cnt <= LIM_CNT);
  // R4: the last frame of a burst drops run unless software rewrites control
  p_selfclear_r4: assert property (@(posedge clk) disable iff (rst)
    (stop_now && !ctrl_wr) |=> !cfg.run);
  // R11: a written length is held
  p_len_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_LEN) |=> cfg.pay_len == $past(reg_wdata));
endmodule

// File: rtl/tpg_framer.sv
module tpg_framer
  import tpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  tpg_cfg_t   cfg,
  input  logic       go,
  output logic [7:0] gen_txd,
  output logic       gen_tx_en,
  output logic       frame_done
);
  tpg_state_t       state;
  logic [REG_W-1:0] pos;
  logic [31:0]      crc;
  logic [31:0]      fcs_word;
  logic [7:0]       cur;
  logic             hashed;

  assign fcs_word   = cfg.bad_fcs ? crc : ~crc;
  assign frame_done = (state == S_FCS) && (pos == REG_W'(FCS_N - 1));
  assign gen_tx_en  = (state != S_IDLE) && (state != S_GAP);
  assign gen_txd    = cur;
  assign hashed     = (state == S_DA) || (state == S_SA) || (state == S_TYPE) || (state == S_PAY);

  always_comb begin
    case (state)
      S_PRE:   cur = 8'h55;
      S_SFD:   cur = 8'hD5;
      S_DA:    cur = pick_byte(cfg.da, pos[2:0]);
      S_SA:    cur = pick_byte(cfg.sa, pos[2:0]);
      S_TYPE:  cur = pos[0] ? cfg.etype[7:0] : cfg.etype[15:8];
      S_PAY:   cur = cfg.pattern;
      S_FCS: begin
        case (pos[1:0])
          2'd0:    cur = fcs_word[7:0];
          2'd1:    cur = fcs_word[15:8];
          2'd2:    cur = fcs_word[23:16];
          default: cur = fcs_word[31:24];
        endcase
      end
      default: cur = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !cfg.gen_en) begin
      state <= S_IDLE;
      pos   <= '0;
    end else begin
      pos <= pos + 1'b1;
      case (state)
        S_IDLE: begin
          pos <= '0;
          if (go) state <= S_PRE;
        end
        S_PRE:  if (pos == REG_W'(PRE_N - 1)) begin state <= S_SFD; pos <= '0; end
        S_SFD:  begin state <= S_DA; pos <= '0; end
        S_DA:   if (pos == REG_W'(ADR_N - 1)) begin state <= S_SA; pos <= '0; end
        S_SA:   if (pos == REG_W'(ADR_N - 1)) begin state <= S_TYPE; pos <= '0; end
        S_TYPE: if (pos == REG_W'(1)) begin
                  state <= (cfg.pay_len == '0) ? S_FCS : S_PAY;
                  pos   <= '0;
                end
        S_PAY:  if (pos == cfg.pay_len - 1'b1) begin state <= S_FCS; pos <= '0; end
        S_FCS:  if (frame_done) begin
                  pos <= '0;
                  if (cfg.gap != '0) state <= S_GAP;
                  else               state <= go ? S_PRE : S_IDLE;
                end
        S_GAP:  if (pos == cfg.gap - 1'b1) begin
                  pos   <= '0;
                  state <= go ? S_PRE : S_IDLE;
                end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               crc <= '1;
    else if (state == S_SFD) crc <= '1;
    else if (hashed)       crc <= crc_step(crc, cur);
  end

  // R3: leaving idle requires the start condition in the previous cycle
  p_start_gated_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |=> (state == S_IDLE || $past(go)));
  // R1: the start delimiter follows the seventh preamble byte
  p_sfd_order_r1: assert property (@(posedge clk) disable iff (rst)
    (state == S_SFD) |-> ($past(state) == S_PRE && $past(pos) == REG_W'(PRE_N - 1)));
endmodule

// File: rtl/eth_test_gen.sv
module eth_test_gen
  import tpg_pkg::*;
#(
  parameter int BURST_LIMIT = 30_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic [7:0]  mac_txd,
  input  logic        mac_tx_en,
  output logic [7:0]  phy_txd,
  output logic        phy_tx_en,
  input  logic [7:0]  phy_rxd,
  input  logic        phy_rx_dv,
  output logic [7:0]  mac_rxd,
  output logic        mac_rx_dv
);
  tpg_cfg_t   cfg;
  logic       go;
  logic       frame_done;
  logic [7:0] gen_txd;
  logic       gen_tx_en;

  tpg_regs #(.BURST_LIMIT(BURST_LIMIT)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_done(frame_done), .cfg(cfg), .go(go)
  );

  tpg_framer u_framer (
    .clk(clk), .rst(rst), .cfg(cfg), .go(go),
    .gen_txd(gen_txd), .gen_tx_en(gen_tx_en), .frame_done(frame_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_txd   <= '0;
      phy_tx_en <= 1'b0;
      mac_rxd   <= '0;
      mac_rx_dv <= 1'b0;
    end else begin
      phy_txd   <= cfg.gen_en ? gen_txd   : mac_txd;
      phy_tx_en <= cfg.gen_en ? gen_tx_en : mac_tx_en;
      mac_rxd   <= cfg.rx_off ? 8'h00 : phy_rxd;
      mac_rx_dv <= cfg.rx_off ? 1'b0  : phy_rx_dv;
    end
  end

  // R2: with the generator on and quiet, MAC traffic never shows on the line
  p_mac_blocked_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg.gen_en && !gen_tx_en) |=> !phy_tx_en);
  // R10: receive-off silences the MAC receive side
  p_rx_off_r10: assert property (@(posedge clk) disable iff (rst)
    cfg.rx_off |=> (!mac_rx_dv && mac_rxd == 8'h00));
endmodule

// File: tb/test_eth_test_gen.sv
module test_eth_test_gen;
  localparam int BURST = 2;
  logic clk = 0;
  logic rst = 1;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic [7:0] mac_txd = 0;
  logic mac_tx_en = 0;
  logic [7:0] phy_txd;
  logic phy_tx_en;
  logic [7:0] phy_rxd = 0;
  logic phy_rx_dv = 0;
  logic [7:0] mac_rxd;
  logic mac_rx_dv;

  int checks = 0, fails = 0;
  logic [7:0] exp_b [0:127];
  int exp_n;
  logic [15:0] c_len, c_gap;
  logic [7:0] c_pat;
  logic c_bad;

  localparam logic [47:0] DA = 48'h0123_4567_89AB;
  localparam logic [47:0] SA = 48'hCAFE_0011_2233;
  localparam logic [15:0] ETY = 16'h0800;
  // {payload length, gap, pattern, bad fcs}
  localparam logic [31:0] VEC [0:3] = '{32'h00_00_A5_00, 32'h01_03_00_01,
                                        32'h11_0C_FF_00, 32'h2E_05_3C_01};

  always #2 clk = ~clk;

  eth_test_gen #(.BURST_LIMIT(BURST)) i_eth_test_gen (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mac_txd(mac_txd), .mac_tx_en(mac_tx_en), .phy_txd(phy_txd),
    .phy_tx_en(phy_tx_en), .phy_rxd(phy_rxd), .phy_rx_dv(phy_rx_dv), .mac_rxd(mac_rxd),
    .mac_rx_dv(mac_rx_dv));

  task automatic check(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic logic [31:0] ref_crc(input int first, input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = first; i < first + n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ exp_b[i][b];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  task automatic build();
    logic [31:0] f;
    exp_n = 0;
    for (int i = 0; i < 7; i++) exp_b[exp_n++] = 8'h55;
    exp_b[exp_n++] = 8'hD5;
    for (int i = 5; i >= 0; i--) exp_b[exp_n++] = DA[i*8 +: 8];
    for (int i = 5; i >= 0; i--) exp_b[exp_n++] = SA[i*8 +: 8];
    exp_b[exp_n++] = ETY[15:8];
    exp_b[exp_n++] = ETY[7:0];
    for (int i = 0; i < int'(c_len); i++) exp_b[exp_n++] = c_pat;
    f = ref_crc(8, exp_n - 8);   // R8
    if (c_bad) f = ~f;           // R9
    for (int i = 0; i < 4; i++) exp_b[exp_n++] = f[i*8 +: 8];
  endtask

  // Collects one frame and then counts idle cycles up to lim.
  task automatic grab(input string req, input int lim, output int gap_seen);
    int t = 0, bad = -1;
    logic [7:0] got = 0;
    while (!phy_tx_en && t < 600) begin @(negedge clk); t++; end
    for (int i = 0; i < exp_n; i++) begin
      if (bad < 0 && (!phy_tx_en || phy_txd !== exp_b[i])) begin bad = i; got = phy_txd; end
      @(negedge clk);
    end
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, int'(got), int'(exp_b[bad]));
    gap_seen = 0;
    while (!phy_tx_en && gap_seen < lim) begin @(negedge clk); gap_seen++; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    int g;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!phy_tx_en && !mac_rx_dv, "R2 reset outputs", phy_tx_en, 0);
    rd(4'd0, r);
    check(r == 16'h0, "R11 reset control", r, 0);

    // R2: pass-through with the generator off
    @(negedge clk); mac_txd = 8'h3A; mac_tx_en = 1;
    @(negedge clk);
    check(phy_tx_en && phy_txd == 8'h3A, "R2 pass-through", phy_txd, 8'h3A);

    // R3: run without generator-enable gives no frame
    mac_tx_en = 0;
    wr(4'd0, 16'h0002);
    g = 0;
    repeat (60) begin @(negedge clk); if (phy_tx_en) g++; end
    check(g == 0, "R3 run without enable", g, 0);

    // R10: receive path with generator on
    wr(4'd0, 16'h0001);
    @(negedge clk); phy_rxd = 8'h77; phy_rx_dv = 1;
    @(negedge clk);
    check(mac_rx_dv && mac_rxd == 8'h77, "R10 rx pass", mac_rxd, 8'h77);
    wr(4'd0, 16'h0011);
    @(negedge clk);
    check(!mac_rx_dv && mac_rxd == 8'h00, "R10 rx off", mac_rxd, 0);
    phy_rx_dv = 0;

    // R2/R3: MAC offers traffic while generator is on and idle
    wr(4'd0, 16'h0001);
    mac_txd = 8'hEE; mac_tx_en = 1;
    g = 0;
    repeat (40) begin @(negedge clk); if (phy_tx_en) g++; end
    check(g == 0, "R2 mac blocked", g, 0);

    // R11: address register readback
    wr(4'd1, DA[47:32]); wr(4'd2, DA[31:16]); wr(4'd3, DA[15:0]);
    wr(4'd4, SA[47:32]); wr(4'd5, SA[31:16]); wr(4'd6, SA[15:0]);
    wr(4'd7, ETY);
    rd(4'd5, r);
    check(r == SA[31:16], "R11 readback", r, SA[31:16]);

    // Vector table: bursts with R1 R4 R6 R7 R8 R9, MAC garbage present
    foreach (VEC[v]) begin
      c_len = {8'd0, VEC[v][31:24]}; c_gap = {8'd0, VEC[v][23:16]};
      c_pat = VEC[v][15:8];          c_bad = VEC[v][0];
      build();
      wr(4'd8, c_len); wr(4'd9, c_gap); wr(4'd10, {8'd0, c_pat});
      wr(4'd0, {12'd0, c_bad, 3'b001});
      wr(4'd0, {12'd0, c_bad, 3'b011});
      grab("R1 R7 R8 R9 frame 1", 400, g);
      check(g == int'(c_gap), "R6 gap", g, c_gap);
      grab("R1 R7 R8 R9 frame 2", 200, g);
      check(g == 200, "R4 burst stops", g, 200);
      rd(4'd0, r);
      check(r[1] == 1'b0, "R4 R11 run self-cleared", r[1], 0);
    end

    // R5: continuous beyond the burst limit, stop mid-frame
    c_len = 16'd20; c_gap = 16'd4; c_pat = 8'h5A; c_bad = 0;
    build();
    wr(4'd8, c_len); wr(4'd9, c_gap); wr(4'd10, {8'd0, c_pat});
    wr(4'd0, 16'h0005);
    wr(4'd0, 16'h0007);
    for (int k = 0; k < 3; k++) begin
      grab("R5 continuous frame", 400, g);
      check(g == 4, "R5 R6 continuous gap", g, 4);
    end
    fork
      begin repeat (12) @(negedge clk); wr(4'd0, 16'h0005); end
      grab("R5 frame completes after stop", 200, g);
    join
    check(g == 200, "R5 stops after frame", g, 200);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule